// File: doc/BRIEF.md
# Page Program-and-Verify Sequencer for Multi-Level Cells

This block runs the incremental step-pulse write of one page of three-bit charge-trap cells that share a single gate line. On a start strobe it captures a page of 3-bit data words, turns each word into a target threshold level through a Gray-coded table, and then alternates high-voltage program pulses with a sweep of verify reads. Because the gate is common to the whole page, every pulse and every verify read acts on all cells at once. Cells are kept out of a pulse through a per-cell inhibit mask that an external driver turns into a channel bias.

Each pulse raises the gate code by a fixed step over the previous one. After each pulse the sequencer lowers the gate to the verify threshold of each level in turn and reads one conduct bit per cell. A cell that targets the level under test and no longer conducts has reached its target, so it joins the inhibit mask. The run ends with a pass when every cell is inhibited. It ends with a fail when the programmable pulse budget is used up first. All voltages appear as unsigned integer codes in millivolts. The analog supplies and the sense amplifiers are outside the block.

Top module: `pgm_verify_seq`

## Requirements
- R1: A start strobe is accepted only while busy is low. Busy rises on the cycle after an accepted start and stays high through the cycle in which done is high. It is low on the following cycle. A start strobe seen while busy has no effect on the run.
- R2: Data maps to target level (0 lowest threshold, 7 highest) as: 111→0, 011→1, 001→2, 101→3, 100→4, 000→5, 010→6, 110→7.
- R3: Cells whose data is 111 (level 0, erased) are inhibited during every pulse of the run.
- R4: During the k-th pulse of a run (k counted from 0), gate_mv equals START_MV + k·STEP_MV. The defaults are 18000 and 300.
- R5: Each pulse holds pulse_en high for exactly PULSE_CYCLES consecutive cycles. During the pulse, bias_mv equals INHIBIT_MV (default 8000). Outside a pulse, bias_mv is 0.
- R6: After every pulse, verify_en is high for seven consecutive cycles. Within that window, verify_lvl runs 1,2,…,7 and gate_mv equals VFY_BASE_MV + L·VFY_STEP_MV (defaults 0 and 600).
- R7: A cell of level L whose sense bit is 0 (not conducting) in the verify cycle of level L becomes inhibited. An inhibited cell stays inhibited until the next start. A cell still below its target threshold stays uninhibited.
- R8: When every cell is inhibited after loading or after a verify sweep, done pulses for one cycle with pass high, and no further pulse is issued. An all-erased page therefore passes with zero pulses, even with a budget of 0.
- R9: When cells remain uninhibited and max_pulses pulses have been issued, done pulses with pass low. Exactly max_pulses pulses are applied.
- R10: pulse_en and verify_en are never high together. Both are low, and gate_mv is 0, outside a run and after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start strobe, honoured only when idle |
| max_pulses | input | CNT_W | Pulse budget for the run |
| wr_data | input | 3·N_CELLS | Packed page data, cell i at bits [3i+2:3i] |
| sense | input | N_CELLS | Per-cell conduct bit during verify (1 = conducts) |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run strobe |
| pass | output | 1 | Result of the last run, valid with done |
| pulse_en | output | 1 | Program pulse active |
| gate_mv | output | 16 | Shared gate voltage code in mV |
| bias_mv | output | 16 | Channel bias code applied to inhibited cells |
| inhibit | output | N_CELLS | Per-cell inhibit mask |
| verify_en | output | 1 | Verify read active |
| verify_lvl | output | 3 | Level under verify |

## Verification
The bench builds the block with 8 cells, 5-cycle pulses and the default voltage codes. It drives a behavioural cell model in which every uninhibited cell gains threshold on each pulse in proportion to the gate code, plus a per-cell speed offset. This size lets a sweep reach every data value on every cell, a page holding all eight levels at once, and mixed pages. A runtime pulse budget brings in the failure paths, the zero-budget case and the all-erased pass within a few thousand cycles. The expected pulse counts come from summing the model's arithmetic threshold gain against each level's verify code.

// File: rtl/pv_pkg.sv
package pv_pkg;

    localparam int MV_W    = 16;
    localparam int LVL_W   = 3;
    localparam int NUM_LVL = 8;

    typedef logic [MV_W-1:0]  mv_t;
    typedef logic [LVL_W-1:0] lvl_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOAD,
        ST_CHECK,
        ST_PULSE,
        ST_VERIFY,
        ST_DONE
    } seq_state_e;

    // phase outputs of the controller
    typedef struct packed {
        logic pulse;
        logic verify;
        lvl_t lvl;
        mv_t  gate;
    } phase_t;

    // Gray ordering of data words over rising threshold
    function automatic lvl_t data_to_level(input logic [2:0] d);
        lvl_t l;
        case (d)
            3'b111:  l = 3'd0;
            3'b011:  l = 3'd1;
            3'b001:  l = 3'd2;
            3'b101:  l = 3'd3;
            3'b100:  l = 3'd4;
            3'b000:  l = 3'd5;
            3'b010:  l = 3'd6;
            default: l = 3'd7;
        endcase
        return l;
    endfunction

    function automatic mv_t linear_mv(input int base, input int step, input int idx);
        return mv_t'(base + step * idx);
    endfunction

endpackage

// File: rtl/pv_level_map.sv
module pv_level_map
    import pv_pkg::*;
#(
    parameter int N_CELLS = 16
) (
    input  logic [N_CELLS*3-1:0]      data_i,
    output logic [N_CELLS-1:0][2:0]   lvls_o,
    output logic [N_CELLS-1:0]        erased_o
);
    for (genvar i = 0; i < N_CELLS; i++) begin : g_cell
        assign lvls_o[i]   = data_to_level(data_i[i*3 +: 3]);
        assign erased_o[i] = (data_i[i*3 +: 3] == 3'b111);
    end
endmodule

// File: rtl/pv_inhibit_tracker.sv
module pv_inhibit_tracker
    import pv_pkg::*;
#(
    parameter int N_CELLS = 16
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     load_i,
    input  logic [N_CELLS-1:0][2:0]  lvls_i,
    input  logic                     verify_i,
    input  lvl_t                     vlev_i,
    input  logic [N_CELLS-1:0]       sense_i,
    output logic [N_CELLS-1:0]       mask_o
);
    logic [N_CELLS-1:0] mask_q;

    for (genvar i = 0; i < N_CELLS; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst) begin
                mask_q[i] <= 1'b0;
            end else if (load_i) begin
                mask_q[i] <= (lvls_i[i] == 3'd0);
            end else if (verify_i && (lvls_i[i] == vlev_i) && !sense_i[i]) begin
                mask_q[i] <= 1'b1;
            end
        end
    end

    assign mask_o = mask_q;

    // R7: an inhibited cell never loses its inhibit except on a reload
    assert_mask_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        !load_i |=> ((mask_q & $past(mask_q)) == $past(mask_q)));

    // R7: a mask bit only appears through load or a failing-to-conduct verify
    assert_mask_source_R7: assert property (@(posedge clk) disable iff (rst)
        (!load_i && !verify_i) |=> (mask_q == $past(mask_q)));
endmodule

// File: rtl/pv_ctrl.sv
module pv_ctrl
    import pv_pkg::*;
#(
    parameter int PULSE_CYCLES = 100,
    parameter int START_MV     = 18000,
    parameter int STEP_MV      = 300,
    parameter int VFY_BASE_MV  = 0,
    parameter int VFY_STEP_MV  = 600,
    parameter int CNT_W        = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [CNT_W-1:0]  max_pulses_i,
    input  logic              all_inh_i,
    output logic              accept_o,
    output logic              load_o,
    output logic              busy_o,
    output logic              done_o,
    output logic              pass_o,
    output phase_t            phase_o
);
    localparam int PC_W = (PULSE_CYCLES > 1) ? $clog2(PULSE_CYCLES) : 1;
    localparam logic [PC_W-1:0] PC_LAST = PC_W'(PULSE_CYCLES - 1);
    localparam lvl_t LVL_TOP = lvl_t'(NUM_LVL - 1);

    seq_state_e         state_q;
    logic [PC_W-1:0]    cyc_q;
    logic [CNT_W-1:0]   pcnt_q;
    lvl_t               vlev_q;
    logic               pass_q;

    assign accept_o = start_i && (state_q == ST_IDLE);
    assign load_o   = (state_q == ST_LOAD);
    assign busy_o   = (state_q != ST_IDLE);
    assign done_o   = (state_q == ST_DONE);
    assign pass_o   = pass_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cyc_q   <= '0;
            pcnt_q  <= '0;
            vlev_q  <= '0;
            pass_q  <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        state_q <= ST_LOAD;
                        pass_q  <= 1'b0;
                        pcnt_q  <= '0;
                    end
                end
                ST_LOAD: state_q <= ST_CHECK;
                ST_CHECK: begin
                    if (all_inh_i) begin
                        state_q <= ST_DONE;
                        pass_q  <= 1'b1;
                    end else if (pcnt_q >= max_pulses_i) begin
                        state_q <= ST_DONE;
                        pass_q  <= 1'b0;
                    end else begin
                        state_q <= ST_PULSE;
                        cyc_q   <= '0;
                    end
                end
                ST_PULSE: begin
                    if (cyc_q == PC_LAST) begin
                        state_q <= ST_VERIFY;
                        vlev_q  <= lvl_t'(1);
                        pcnt_q  <= pcnt_q + 1'b1;
                    end else begin
                        cyc_q <= cyc_q + 1'b1;
                    end
                end
                ST_VERIFY: begin
                    if (vlev_q == LVL_TOP) begin
                        state_q <= ST_CHECK;
                    end else begin
                        vlev_q <= vlev_q + 1'b1;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        phase_o = '0;
        if (state_q == ST_PULSE) begin
            phase_o.pulse = 1'b1;
            phase_o.gate  = linear_mv(START_MV, STEP_MV, int'(pcnt_q));
        end else if (state_q == ST_VERIFY) begin
            phase_o.verify = 1'b1;
            phase_o.lvl    = vlev_q;
            phase_o.gate   = linear_mv(VFY_BASE_MV, VFY_STEP_MV, int'(vlev_q));
        end
    end

    // R10: pulse and verify never overlap
    assert_phase_excl_R10: assert property (@(posedge clk) disable iff (rst)
        !(phase_o.pulse && phase_o.verify));

    // R1: done only appears inside a busy window
    assert_done_busy_R1: assert property (@(posedge clk) disable iff (rst)
        done_o |-> busy_o);

    // R5: the gate code holds still across one pulse
    assert_pulse_gate_stable_R5: assert property (@(posedge clk) disable iff (rst)
        (phase_o.pulse && $past(phase_o.pulse)) |-> $stable(phase_o.gate));

    // R6: verify levels advance by one per cycle
    assert_verify_order_R6: assert property (@(posedge clk) disable iff (rst)
        (phase_o.verify && phase_o.lvl != LVL_TOP) |=> (phase_o.verify && phase_o.lvl == $past(phase_o.lvl) + 1'b1));

    // R9: budget exhausted with work left ends in a fail
    assert_budget_fail_R9: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_CHECK && !all_inh_i && pcnt_q >= max_pulses_i) |=> (done_o && !pass_o));

    // R8: a finished page never receives another pulse
    assert_no_pulse_after_pass_R8: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_CHECK && all_inh_i) |=> (done_o && pass_o && !phase_o.pulse));
endmodule

// File: rtl/pgm_verify_seq.sv
module pgm_verify_seq
    import pv_pkg::*;
#(
    parameter int N_CELLS      = 16,
    parameter int PULSE_CYCLES = 10000,
    parameter int START_MV     = 18000,
    parameter int STEP_MV      = 300,
    parameter int INHIBIT_MV   = 8000,
    parameter int VFY_BASE_MV  = 0,
    parameter int VFY_STEP_MV  = 600,
    parameter int CNT_W        = 8
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   start,
    input  logic [CNT_W-1:0]       max_pulses,
    input  logic [N_CELLS*3-1:0]   wr_data,
    input  logic [N_CELLS-1:0]     sense,
    output logic                   busy,
    output logic                   done,
    output logic                   pass,
    output logic                   pulse_en,
    output logic [MV_W-1:0]        gate_mv,
    output logic [MV_W-1:0]        bias_mv,
    output logic [N_CELLS-1:0]     inhibit,
    output logic                   verify_en,
    output logic [LVL_W-1:0]       verify_lvl
);
    localparam int DATA_W = N_CELLS * 3;

    logic [DATA_W-1:0]          data_q;
    logic [N_CELLS-1:0][2:0]    lvls;
    logic [N_CELLS-1:0]         erased;
    logic [N_CELLS-1:0]         mask;
    logic                       accept;
    logic                       load;
    phase_t                     phase;

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q <= '0;
        end else if (accept) begin
            data_q <= wr_data;
        end
    end

    pv_level_map #(.N_CELLS(N_CELLS)) map_i (
        .data_i   (data_q),
        .lvls_o   (lvls),
        .erased_o (erased)
    );

    pv_ctrl #(
        .PULSE_CYCLES (PULSE_CYCLES),
        .START_MV     (START_MV),
        .STEP_MV      (STEP_MV),
        .VFY_BASE_MV  (VFY_BASE_MV),
        .VFY_STEP_MV  (VFY_STEP_MV),
        .CNT_W        (CNT_W)
    ) ctrl_i (
        .clk          (clk),
        .rst          (rst),
        .start_i      (start),
        .max_pulses_i (max_pulses),
        .all_inh_i    (&mask),
        .accept_o     (accept),
        .load_o       (load),
        .busy_o       (busy),
        .done_o       (done),
        .pass_o       (pass),
        .phase_o      (phase)
    );

    pv_inhibit_tracker #(.N_CELLS(N_CELLS)) trk_i (
        .clk      (clk),
        .rst      (rst),
        .load_i   (load),
        .lvls_i   (lvls),
        .verify_i (phase.verify),
        .vlev_i   (phase.lvl),
        .sense_i  (sense),
        .mask_o   (mask)
    );

    assign pulse_en   = phase.pulse;
    assign verify_en  = phase.verify;
    assign verify_lvl = phase.lvl;
    assign gate_mv    = phase.gate;
    assign bias_mv    = phase.pulse ? mv_t'(INHIBIT_MV) : '0;
    assign inhibit    = mask;

    // R3: erased cells are shielded during every pulse
    assert_erased_inhibited_R3: assert property (@(posedge clk) disable iff (rst)
        pulse_en |-> ((inhibit & erased) == erased));

    // R8: a passing run ends with the whole page inhibited
    assert_pass_all_inhibited_R8: assert property (@(posedge clk) disable iff (rst)
        (done && pass) |-> (&inhibit));

    // R10: idle means no gate activity
    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!pulse_en && !verify_en && gate_mv == '0));
endmodule

// File: tb/pgm_verify_seq_tb.sv
module pgm_verify_seq_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int N          = 8;
    localparam int PCYC       = 5;
    localparam int CW         = 8;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            start = 1'b0;
    logic [CW-1:0]   max_pulses = 8'd12;
    logic [N*3-1:0]  wr_data = '0;
    logic [N-1:0]    sense;
    logic            busy, done, pass, pulse_en, verify_en;
    logic [15:0]     gate_mv, bias_mv;
    logic [N-1:0]    inhibit;
    logic [2:0]      verify_lvl;

    int n_checks = 0;
    int n_fail   = 0;

    // behavioural cell array
    int vt [N];
    int cell_lvl [N];
    int kp, plen, vexp;

    pgm_verify_seq #(
        .N_CELLS(N), .PULSE_CYCLES(PCYC), .CNT_W(CW)
    ) dut_i (
        .clk(clk), .rst(rst), .start(start), .max_pulses(max_pulses),
        .wr_data(wr_data), .sense(sense), .busy(busy), .done(done), .pass(pass),
        .pulse_en(pulse_en), .gate_mv(gate_mv), .bias_mv(bias_mv),
        .inhibit(inhibit), .verify_en(verify_en), .verify_lvl(verify_lvl)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always_comb begin
        for (int i = 0; i < N; i++)
            sense[i] = verify_en && (vt[i] < int'(gate_mv));
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int lvl_of(input int d);
        case (d)
            7: return 0;  3: return 1;  1: return 2;  5: return 3;
            4: return 4;  0: return 5;  2: return 6;  default: return 7;
        endcase
    endfunction

    // monitor and cell model, all at the falling edge
    always @(negedge clk) begin
        if (!rst) begin
            if (pulse_en) begin
                chk(gate_mv == 16'(18000 + 300*kp), "R4", "pulse gate code", int'(gate_mv), 18000 + 300*kp);
                chk(bias_mv == 16'd8000, "R5", "bias during pulse", int'(bias_mv), 8000);
                if (plen == 0) begin
                    for (int i = 0; i < N; i++) begin
                        if (cell_lvl[i] == 0)
                            chk(inhibit[i], "R3", "erased cell inhibit", int'(inhibit[i]), 1);
                        else
                            chk(inhibit[i] == (vt[i] >= 600*cell_lvl[i]), "R7", "inhibit vs threshold",
                                int'(inhibit[i]), int'(vt[i] >= 600*cell_lvl[i]));
                        if (!inhibit[i])
                            vt[i] += int'(gate_mv) - 17800 + 50*(i%4);
                    end
                end
                plen++;
            end else begin
                chk(bias_mv == 16'd0, "R5", "bias outside pulse", int'(bias_mv), 0);
                if (plen > 0) begin
                    chk(plen == PCYC, "R5", "pulse length", plen, PCYC);
                    plen = 0;
                    kp++;
                    vexp = 1;
                end
            end
            if (verify_en) begin
                chk(int'(verify_lvl) == vexp, "R6", "verify level order", int'(verify_lvl), vexp);
                chk(int'(gate_mv) == 600*vexp, "R6", "verify gate code", int'(gate_mv), 600*vexp);
                chk(!pulse_en, "R10", "pulse during verify", int'(pulse_en), 0);
                vexp = (vexp == 7) ? 1 : vexp + 1;
            end
        end
    end

    task automatic run(input int d[N], input int maxp, input bit poke);
        int need, expk, nn, v;
        bit exp_pass;
        expk = 0;
        exp_pass = 1'b1;
        for (int i = 0; i < N; i++) begin
            cell_lvl[i] = lvl_of(d[i]);
            wr_data[i*3 +: 3] = 3'(d[i]);
            vt[i] = -500;
            v = -500; nn = 0;
            if (cell_lvl[i] > 0)
                while (v < 600*cell_lvl[i]) begin
                    v += 200 + 300*nn + 50*(i%4);
                    nn++;
                end
            if (nn > expk) expk = nn;
        end
        need = expk;
        if (need > maxp) begin
            exp_pass = 1'b0;
            expk = maxp;
        end
        kp = 0; plen = 0; vexp = 1;
        max_pulses = CW'(maxp);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy, "R1", "busy after start", int'(busy), 1);
        if (poke) begin
            repeat (3) @(negedge clk);
            wr_data = '0;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        while (!done) @(negedge clk);
        chk(busy, "R1", "busy with done", int'(busy), 1);
        chk(pass == exp_pass, exp_pass ? "R8" : "R9", "pass flag", int'(pass), int'(exp_pass));
        chk(kp == expk, exp_pass ? "R8" : "R9", "pulse count", kp, expk);
        for (int i = 0; i < N; i++) begin
            if (cell_lvl[i] == 0)
                chk(vt[i] == -500, "R3", "erased cell untouched", vt[i], -500);
            else if (exp_pass)
                chk(vt[i] >= 600*cell_lvl[i], "R2", "cell reached its level", vt[i], 600*cell_lvl[i]);
        end
        @(negedge clk);
        chk(!busy && !done, "R1", "idle after done", int'(busy), 0);
        chk(!pulse_en && !verify_en && gate_mv == 0, "R10", "idle outputs", int'(gate_mv), 0);
        chk(kp == expk, "R8", "no pulse after end", kp, expk);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        int d[N];
        for (int i = 0; i < N; i++) begin vt[i] = -500; cell_lvl[i] = 0; end
        kp = 0; plen = 0; vexp = 1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!busy && !done && !pulse_en && !verify_en, "R10", "reset state", int'(busy), 0);
        chk(gate_mv == 0 && inhibit == '0, "R10", "reset gate/mask", int'(gate_mv), 0);

        // every data value on the whole page
        for (int v = 0; v < 8; v++) begin
            for (int i = 0; i < N; i++) d[i] = v;
            run(d, 12, v == 6);
        end
        // one cell per level, via the data code of each level
        d = '{7, 3, 1, 5, 4, 0, 2, 6};
        run(d, 12, 1'b1);
        // mixed pages
        for (int t = 0; t < 16; t++) begin
            for (int i = 0; i < N; i++) d[i] = (t*5 + i*3 + (t*i)/2) % 8;
            run(d, 12, 1'b0);
        end
        // budget limits
        for (int i = 0; i < N; i++) d[i] = 6;
        run(d, 3, 1'b0);
        d = '{7, 3, 1, 5, 4, 0, 2, 6};
        run(d, 0, 1'b0);
        run(d, 2, 1'b0);
        for (int i = 0; i < N; i++) d[i] = 7;
        run(d, 0, 1'b0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule